// File: doc/BRIEF.md
# SPI Interrupt Set/Clear Register Bank

This block is the interrupt front end of a serial peripheral controller. It owns two seven-bit vectors: a sticky event record and an enable mask. Single-cycle event pulses from the transfer engine set bits in the event record. Software acknowledges an event by writing a one to that bit's position. The mask is never written as a whole word. Software sets bits in it through one write-only port and clears bits through a second write-only port, and reads it back at a third address.

The block decodes four word addresses on a simple write/read strobe interface. All four addresses use the same bit layout. A single registered, level-sensitive interrupt request goes high when any event bit is both recorded and enabled. Read data is registered: it is returned in the cycle after the read strobe and held until the next read.

Top module: `spi_irq_bank`

## Requirements
- R1: After a synchronous reset, the event record, the mask, `irq_o` and `rdata_o` are all zero.
- R2: A one on bit i of `evt_i` sets event bit i at the next clock edge. Reading address 0x04 returns the event record in bits 6:0. Bit 1 is mode fault, bit 2 is TX below watermark, bit 3 is TX full, and bit 4 is RX not empty.
- R3: A write to 0x04 clears each event bit whose write-data bit is 1. Event bits whose write-data bit is 0 keep their value.
- R4: A write to 0x08 sets each mask bit whose write-data bit is 1. Zero bits leave the mask unchanged. Reading 0x10 returns the mask in bits 6:0.
- R5: A write to 0x0C clears each mask bit whose write-data bit is 1. Zero bits leave the mask unchanged.
- R6: Reads of 0x08, 0x0C and any undecoded address return zero. Bits above bit 6 always read zero.
- R7: `irq_o` in each cycle equals the OR over (event record AND mask) as they stood before the preceding clock edge. This gives one register of latency.
- R8: If an event pulse and a clearing write hit the same bit in the same cycle, the bit stays set.
- R9: Writes to 0x10 or to any undecoded address change neither the event record nor the mask.
- R10: `rdata_o` updates only at an edge where `rd_en_i` is high. It then shows the addressed register as it stood before that edge. It holds its value otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en_i | input | 1 | Write strobe |
| rd_en_i | input | 1 | Read strobe |
| addr_i | input | ADDR_W (6) | Byte address of the access |
| wdata_i | input | DATA_W (32) | Write data |
| evt_i | input | N_SRC (7) | Event pulses from the transfer engine |
| rdata_o | output | DATA_W (32) | Registered read data |
| irq_o | output | 1 | Registered interrupt request |

## Verification
The checker looks at every cycle for four things: a pulsed event bit is present one edge later, an event bit falls only under a clearing write to its position, the mask moves only on writes to the set or clear ports, and the request line follows the masked event record with one cycle of delay. Several behaviours can only be shown by the bench's scenarios. These are read-data values and their hold behaviour, the zero read of the write-only ports and of unused addresses, the lack of effect of zero bits and of writes to the readback address, and the exact outcome of an event colliding with a clear. The bench compares each of these against a reference model across directed cases and a long seeded random run.

// File: rtl/spi_irq_pkg.sv
package spi_irq_pkg;

  // one-hot register selection produced by the address decoder
  typedef struct packed {
    logic stat;   // event record, write-one-to-clear
    logic set;    // mask set port, write-only
    logic clr;    // mask clear port, write-only
    logic msk;    // mask readback, read-only
  } irq_sel_t;

endpackage

// File: rtl/spi_irq_decode.sv
module spi_irq_decode
  import spi_irq_pkg::*;
#(
  parameter int ADDR_W   = 6,
  parameter int OFF_STAT = 'h04,
  parameter int OFF_SET  = 'h08,
  parameter int OFF_CLR  = 'h0C,
  parameter int OFF_MSK  = 'h10
) (
  input  logic [ADDR_W-1:0] addr_i,
  output irq_sel_t          sel_o
);

  always_comb begin
    sel_o      = '0;
    sel_o.stat = (addr_i == ADDR_W'(OFF_STAT));
    sel_o.set  = (addr_i == ADDR_W'(OFF_SET));
    sel_o.clr  = (addr_i == ADDR_W'(OFF_CLR));
    sel_o.msk  = (addr_i == ADDR_W'(OFF_MSK));
  end

endmodule

// File: rtl/spi_irq_status.sv
module spi_irq_status #(
  parameter int N_SRC = 7
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [N_SRC-1:0] evt_i,
  input  logic             ack_we_i,
  input  logic [N_SRC-1:0] ack_bits_i,
  output logic [N_SRC-1:0] status_o
);

  // each bit: an event wins over an acknowledge in the same cycle
  for (genvar i = 0; i < N_SRC; i++) begin : g_bit
    always_ff @(posedge clk) begin
      if (rst)
        status_o[i] <= 1'b0;
      else if (evt_i[i])
        status_o[i] <= 1'b1;
      else if (ack_we_i && ack_bits_i[i])
        status_o[i] <= 1'b0;
    end
  end

endmodule

// File: rtl/spi_irq_mask.sv
module spi_irq_mask #(
  parameter int N_SRC = 7
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             set_we_i,
  input  logic             clr_we_i,
  input  logic [N_SRC-1:0] bits_i,
  output logic [N_SRC-1:0] mask_o
);

  always_ff @(posedge clk) begin
    if (rst)
      mask_o <= '0;
    else if (set_we_i)
      mask_o <= mask_o | bits_i;
    else if (clr_we_i)
      mask_o <= mask_o & ~bits_i;
  end

endmodule

// File: rtl/spi_irq_bank.sv
module spi_irq_bank
  import spi_irq_pkg::*;
#(
  parameter int N_SRC    = 7,
  parameter int ADDR_W   = 6,
  parameter int DATA_W   = 32,
  parameter int OFF_STAT = 'h04,
  parameter int OFF_SET  = 'h08,
  parameter int OFF_CLR  = 'h0C,
  parameter int OFF_MSK  = 'h10
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en_i,
  input  logic              rd_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [N_SRC-1:0]  evt_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              irq_o
);

  localparam int PAD_W = DATA_W - N_SRC;

  irq_sel_t         sel;
  logic [N_SRC-1:0] status_q;
  logic [N_SRC-1:0] mask_q;
  logic [N_SRC-1:0] rd_val;

  spi_irq_decode #(
    .ADDR_W(ADDR_W), .OFF_STAT(OFF_STAT), .OFF_SET(OFF_SET),
    .OFF_CLR(OFF_CLR), .OFF_MSK(OFF_MSK)
  ) u_dec (
    .addr_i(addr_i),
    .sel_o (sel)
  );

  spi_irq_status #(.N_SRC(N_SRC)) u_stat (
    .clk       (clk),
    .rst       (rst),
    .evt_i     (evt_i),
    .ack_we_i  (wr_en_i && sel.stat),
    .ack_bits_i(wdata_i[N_SRC-1:0]),
    .status_o  (status_q)
  );

  spi_irq_mask #(.N_SRC(N_SRC)) u_msk (
    .clk     (clk),
    .rst     (rst),
    .set_we_i(wr_en_i && sel.set),
    .clr_we_i(wr_en_i && sel.clr),
    .bits_i  (wdata_i[N_SRC-1:0]),
    .mask_o  (mask_q)
  );

  // write-only ports and unused addresses read as zero
  always_comb begin
    rd_val = '0;
    if (sel.stat) rd_val = status_q;
    if (sel.msk)  rd_val = mask_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata_o <= '0;
      irq_o   <= 1'b0;
    end else begin
      if (rd_en_i) rdata_o <= {{PAD_W{1'b0}}, rd_val};
      irq_o <= |(status_q & mask_q);
    end
  end

endmodule

// File: rtl/spi_irq_bank_chk.sv
module spi_irq_bank_chk #(
  parameter int N_SRC    = 7,
  parameter int ADDR_W   = 6,
  parameter int DATA_W   = 32,
  parameter int OFF_STAT = 'h04,
  parameter int OFF_SET  = 'h08,
  parameter int OFF_CLR  = 'h0C
) (
  input logic              clk,
  input logic              rst,
  input logic              wr_en_i,
  input logic [ADDR_W-1:0] addr_i,
  input logic [DATA_W-1:0] wdata_i,
  input logic [N_SRC-1:0]  evt_i,
  input logic [N_SRC-1:0]  status_q,
  input logic [N_SRC-1:0]  mask_q,
  input logic              irq_o
);

  logic             ack_wr;
  logic             msk_wr;
  logic [N_SRC-1:0] ack_bits;

  assign ack_wr   = wr_en_i && (addr_i == ADDR_W'(OFF_STAT));
  assign msk_wr   = wr_en_i && ((addr_i == ADDR_W'(OFF_SET)) || (addr_i == ADDR_W'(OFF_CLR)));
  assign ack_bits = ack_wr ? wdata_i[N_SRC-1:0] : '0;

  AST_EVT_SETS: assert property (@(posedge clk) disable iff (rst)
    (evt_i != '0) |=> ((status_q & $past(evt_i)) == $past(evt_i))); // R2

  AST_FALL_ONLY_ON_ACK: assert property (@(posedge clk) disable iff (rst)
    (!rst) |=> ((($past(status_q) & ~status_q) & ~$past(ack_bits)) == '0)); // R3

  AST_MASK_PORTS_ONLY: assert property (@(posedge clk) disable iff (rst)
    (!msk_wr) |=> $stable(mask_q)); // R9

  AST_IRQ_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
    (!rst) |=> (irq_o == $past(|(status_q & mask_q)))); // R7

endmodule

bind spi_irq_bank spi_irq_bank_chk #(
  .N_SRC(N_SRC), .ADDR_W(ADDR_W), .DATA_W(DATA_W),
  .OFF_STAT(OFF_STAT), .OFF_SET(OFF_SET), .OFF_CLR(OFF_CLR)
) u_chk (
  .clk     (clk),
  .rst     (rst),
  .wr_en_i (wr_en_i),
  .addr_i  (addr_i),
  .wdata_i (wdata_i),
  .evt_i   (evt_i),
  .status_q(status_q),
  .mask_q  (mask_q),
  .irq_o   (irq_o)
);

// File: tb/spi_irq_bank_test.sv
module spi_irq_bank_test;

  localparam int N  = 7;
  localparam int AW = 6;
  localparam int DW = 32;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          wr_en = 1'b0;
  logic          rd_en = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] wdata = '0;
  logic [N-1:0]  evt = '0;
  logic [DW-1:0] rdata;
  logic          irq;

  int total = 0;
  int bad   = 0;
  int cycles = 0;
  bit finished = 1'b0;

  // reference model state
  logic [N-1:0]  ms = '0;
  logic [N-1:0]  mm = '0;
  logic [DW-1:0] exp_rd = '0;
  logic          exp_irq = 1'b0;

  always #2 clk = ~clk;  // 250 MHz

  spi_irq_bank uut (
    .clk(clk), .rst(rst), .wr_en_i(wr_en), .rd_en_i(rd_en),
    .addr_i(addr), .wdata_i(wdata), .evt_i(evt),
    .rdata_o(rdata), .irq_o(irq)
  );

  function automatic logic [DW-1:0] model_read(input logic [AW-1:0] a);
    case (a)
      6'h04:   return {{(DW-N){1'b0}}, ms};
      6'h10:   return {{(DW-N){1'b0}}, mm};
      default: return '0;
    endcase
  endfunction

  task automatic check(input logic [DW-1:0] act, input logic [DW-1:0] exp, input string tag);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  // one bus cycle: drive at negedge, model the edge, check at next negedge
  task automatic step(input logic we, input logic [AW-1:0] a, input logic [DW-1:0] wd,
                      input logic re, input logic [N-1:0] ev, input string tag);
    wr_en = we; addr = a; wdata = wd; rd_en = re; evt = ev;
    @(posedge clk);
    exp_irq = |(ms & mm);
    if (re) exp_rd = model_read(a);
    if (we && a == 6'h04) ms = ms & ~wd[N-1:0];
    ms = ms | ev;
    if (we && a == 6'h08) mm = mm | wd[N-1:0];
    if (we && a == 6'h0C) mm = mm & ~wd[N-1:0];
    @(negedge clk);
    check({31'b0, irq}, {31'b0, exp_irq}, "R7 irq level");
    check(rdata, exp_rd, tag);
  endtask

  function automatic logic [AW-1:0] pick_addr(input int unsigned r);
    case (r % 7)
      0: return 6'h04;
      1: return 6'h08;
      2: return 6'h0C;
      3: return 6'h10;
      4: return 6'h04;
      5: return 6'h00;
      default: return 6'h14;
    endcase
  endfunction

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 100000 && !finished) begin
        bad++; total++;
        $display("FAIL watchdog: got %0d cycles expected fewer", cycles);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
      end
    end
  end

  initial begin
    void'($urandom(32'h5EED_1234));
    repeat (3) @(negedge clk);
    rst = 1'b0;
    check(rdata, '0, "R1 rdata after reset");
    check({31'b0, irq}, '0, "R1 irq after reset");
    step(0, 6'h04, '0, 1, '0, "R1 event record zero");
    step(0, 6'h10, '0, 1, '0, "R1 mask zero");

    step(0, 6'h00, '0, 0, 7'h12, "R10 hold");
    step(0, 6'h04, '0, 1, '0, "R2 events recorded");
    step(1, 6'h08, 32'h02, 0, '0, "R10 hold");
    step(0, 6'h10, '0, 1, '0, "R4 mask set");
    step(1, 6'h08, 32'h00, 0, '0, "R4 zero set write");
    step(0, 6'h10, '0, 1, '0, "R4 mask unchanged");
    step(1, 6'h04, 32'h00, 1, '0, "R3 zero ack write");
    step(0, 6'h04, '0, 1, '0, "R3 record unchanged");
    step(1, 6'h04, 32'h10, 0, '0, "R10 hold");
    step(0, 6'h04, '0, 1, '0, "R3 bit cleared");
    step(1, 6'h04, 32'h02, 0, 7'h02, "R10 hold");
    step(0, 6'h04, '0, 1, '0, "R8 collision keeps bit");
    step(1, 6'h0C, 32'h00, 0, '0, "R10 hold");
    step(0, 6'h10, '0, 1, '0, "R5 zero clear write");
    step(1, 6'h0C, 32'h02, 0, '0, "R10 hold");
    step(0, 6'h10, '0, 1, '0, "R5 mask cleared");
    step(1, 6'h08, 32'hFFFF_FFFF, 0, '0, "R10 hold");
    step(0, 6'h08, '0, 1, '0, "R6 set port reads zero");
    step(0, 6'h0C, '0, 1, '0, "R6 clear port reads zero");
    step(0, 6'h3C, '0, 1, '0, "R6 unused reads zero");
    step(0, 6'h10, '0, 1, '0, "R6 upper bits zero");
    step(1, 6'h10, 32'h00, 0, '0, "R10 hold");
    step(1, 6'h14, 32'h7F, 0, '0, "R10 hold");
    step(0, 6'h10, '0, 1, '0, "R9 readback write ignored");
    step(1, 6'h04, 32'h7F, 0, 7'h08, "R8 level source reasserts");
    step(0, 6'h04, '0, 1, '0, "R8 level source present");

    for (int k = 0; k < 3000; k++) begin
      int unsigned r = $urandom;
      step(r[0], pick_addr($urandom), $urandom, r[1],
           N'($urandom & $urandom & $urandom), "R10 random read");
    end

    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule